// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table with Pending Array

This block holds a small table of interrupt vectors for an endpoint device. Each vector has a 64-bit message address, a 32-bit message data word and a mask bit. Together with a pending-bit array, the table sits in a 4 KiB register window and is reached by 32-bit reads and writes on a simple request bus. Device logic raises an interrupt by pulsing a request with a vector number. The block then either emits one message write (address and data) on a valid/ready output, or records a pending bit for later delivery.

Device logic also keeps a use count per vector, raised and lowered through a small increment/decrement port. A request for a vector whose count is zero is dropped. Lowering a count to zero discards that vector's pending bit. Software unmasks a vector by writing its control word. If that vector was pending, the stored message goes out on its own, without a fresh request. Whenever the output is free, pending unmasked vectors are replayed, lowest index first.

The external reset is asynchronous and active-low. It is released through a two-stage synchroniser, so state leaves reset two clock edges after the pin rises.

Top module: `vecmsg_ctrl`

## Requirements
- R1: After reset, every table word reads zero except each configured vector's control word, which reads 1 (masked). The pending word reads zero, every use count is zero and `msg_valid` is low.
- R2: A word write (`bus_size` = 2'b10) at offset v*16 + {0, 4, 8, 12} sets vector v's address low word, address high word, data word or control word. A read of the same offset returns the stored value on `bus_rdata` one cycle after the request. The control word keeps only bit 0, the mask.
- R3: A read with `bus_size` other than 2'b10 returns zero. A write with `bus_size` other than 2'b10 changes nothing and raises `bus_err` for the one cycle after the request.
- R4: Writes with address bit 11 set (offset 0x800 and above) are ignored. A read at 0x800 returns the pending array, with bit v standing for vector v. Reads of other words at or above 0x800, and of table words of vectors at or above `NUM_VEC`, return zero.
- R5: An interrupt request for a vector at or above `NUM_VEC`, or for a vector whose use count is zero, produces no message and no pending bit.
- R6: An interrupt request for a masked vector that is in use sets its pending bit and produces no message.
- R7: An interrupt request for an unmasked vector that is in use, made while the output is free, raises `msg_valid` one cycle later. `msg_addr` then equals {high word, low word} and `msg_data` equals the data word. All three hold steady until `msg_ready` is seen high.
- R8: When a table write leaves a pending vector unmasked, its pending bit clears and its message becomes valid on the second clock edge after the write.
- R9: While a message waits on the output, a request for an unmasked vector that is in use sets its pending bit. When the output frees, pending unmasked vectors are sent one per handshake, lowest index first.
- R10: An increment of a vector at or above `NUM_VEC` raises `use_err` for one cycle. An increment stops at the counter maximum (2^`CNT_W`-1). A decrement of a zero count, or of an out-of-range vector, has no effect.
- R11: A decrement that brings a use count to zero clears that vector's pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the 4 KiB window |
| bus_size | input | 2 | Access size: 2'b00 byte, 2'b01 halfword, 2'b10 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| bus_err | output | 1 | Sub-word write rejected (one-cycle pulse) |
| irq_req | input | 1 | Interrupt request strobe |
| irq_vec | input | 5 | Vector of the interrupt request |
| use_inc | input | 1 | Raise the use count of `use_vec` |
| use_dec | input | 1 | Lower the use count of `use_vec` (ignored when `use_inc` is high) |
| use_vec | input | 5 | Vector for the use-count operation |
| use_err | output | 1 | Out-of-range increment (one-cycle pulse) |
| msg_valid | output | 1 | Message write waiting |
| msg_ready | input | 1 | Consumer takes the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Read data, `bus_err` and `use_err` are due one clock edge after the request edge. A direct message is due one edge after its interrupt request. A replay caused by an unmasking write is due one edge later than that, because the write must first land in the mask register. A replay on a free output appears on the same edge that consumes the previous message. The bench drives every input on the falling edge and samples on a later falling edge that lies exactly that many rising edges on. It checks that `msg_valid` is still low one cycle after an unmasking write and high the cycle after, so an early or late replay is reported.

// File: rtl/vm_pkg.sv
package vm_pkg;
  localparam int MAX_VEC = 32;
  localparam int VW      = 5;
  localparam int AW      = 12;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef enum logic [1:0] {
    FLD_LO   = 2'd0,
    FLD_HI   = 2'd1,
    FLD_DATA = 2'd2,
    FLD_CTRL = 2'd3
  } fld_e;
endpackage

// File: rtl/vm_table.sv
module vm_table
  import vm_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [AW-1:2]      bus_addr,
  input  logic [1:0]         bus_size,
  input  logic [31:0]        bus_wdata,
  input  logic [MAX_VEC-1:0] pend_i,
  input  logic [VW-1:0]      lk_vec,
  output logic [MAX_VEC-1:0] mask_o,
  output logic [63:0]        lk_addr,
  output logic [31:0]        lk_data,
  output logic [31:0]        bus_rdata,
  output logic               bus_err
);
  logic [31:0] lo_q [NUM_VEC];
  logic [31:0] lo_d [NUM_VEC];
  logic [31:0] hi_q [NUM_VEC];
  logic [31:0] hi_d [NUM_VEC];
  logic [31:0] dat_q[NUM_VEC];
  logic [31:0] dat_d[NUM_VEC];
  logic [NUM_VEC-1:0] mask_q, mask_d;
  logic [31:0] rdata_q, rd_val;
  logic        err_q, err_d;

  logic       word_ok, in_pend, wr_en, rd_en;
  logic [6:0] tvec;
  fld_e       fld;

  assign word_ok = (bus_size == SZ_WORD);
  assign in_pend = bus_addr[11];
  assign tvec    = bus_addr[10:4];
  assign fld     = fld_e'(bus_addr[3:2]);
  assign wr_en   = bus_req && bus_we && word_ok && !in_pend;
  assign rd_en   = bus_req && !bus_we;
  assign err_d   = bus_req && bus_we && !word_ok;

  // Table write next-state
  always_comb begin
    mask_d = mask_q;
    for (int i = 0; i < NUM_VEC; i++) begin
      lo_d[i]  = lo_q[i];
      hi_d[i]  = hi_q[i];
      dat_d[i] = dat_q[i];
      if (wr_en && tvec == 7'(i)) begin
        case (fld)
          FLD_LO:   lo_d[i]   = bus_wdata;
          FLD_HI:   hi_d[i]   = bus_wdata;
          FLD_DATA: dat_d[i]  = bus_wdata;
          FLD_CTRL: mask_d[i] = bus_wdata[0];
          default:  ;
        endcase
      end
    end
  end

  // Read mux
  always_comb begin
    rd_val = '0;
    if (word_ok) begin
      if (in_pend) begin
        if (bus_addr[10:2] == '0) rd_val = 32'(pend_i);
      end else begin
        for (int i = 0; i < NUM_VEC; i++) begin
          if (tvec == 7'(i)) begin
            case (fld)
              FLD_LO:   rd_val = lo_q[i];
              FLD_HI:   rd_val = hi_q[i];
              FLD_DATA: rd_val = dat_q[i];
              FLD_CTRL: rd_val = {31'b0, mask_q[i]};
              default:  ;
            endcase
          end
        end
      end
    end
  end

  // Message lookup for the issuing vector
  always_comb begin
    lk_addr = '0;
    lk_data = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (lk_vec == VW'(i)) begin
        lk_addr = {hi_q[i], lo_q[i]};
        lk_data = dat_q[i];
      end
    end
  end

  for (genvar g = 0; g < MAX_VEC; g++) begin : g_mask
    if (g < NUM_VEC) begin : g_cfg
      assign mask_o[g] = mask_q[g];
    end else begin : g_absent
      assign mask_o[g] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
        dat_q[i] <= '0;
      end
      mask_q <= '1;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        lo_q[i]  <= lo_d[i];
        hi_q[i]  <= hi_d[i];
        dat_q[i] <= dat_d[i];
      end
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

  // R3: a rejected sub-word write leaves the mask bits untouched
  a_r3_subword_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_size != SZ_WORD) |=> $stable(mask_q));
  // R4: writes into the pending region leave the mask bits untouched
  a_r4_pend_region_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr[11]) |=> $stable(mask_q));
endmodule

// File: rtl/vm_usecnt.sv
module vm_usecnt
  import vm_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               use_inc,
  input  logic               use_dec,
  input  logic [VW-1:0]      use_vec,
  output logic [MAX_VEC-1:0] used_o,
  output logic [MAX_VEC-1:0] clr_o,
  output logic               use_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q[NUM_VEC];
  logic [CNT_W-1:0] cnt_d[NUM_VEC];
  logic             err_q, err_d;
  logic             cnt_en;

  assign cnt_en = use_inc || use_dec;
  assign err_d  = use_inc && (32'(use_vec) >= NUM_VEC);

  always_comb begin
    clr_o = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      cnt_d[i] = cnt_q[i];
      if (use_vec == VW'(i)) begin
        if (use_inc) begin
          if (cnt_q[i] != CNT_MAX) cnt_d[i] = cnt_q[i] + 1'b1;
        end else if (use_dec && cnt_q[i] != '0) begin
          cnt_d[i] = cnt_q[i] - 1'b1;
          if (cnt_q[i] == CNT_W'(1)) clr_o[i] = 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < MAX_VEC; g++) begin : g_used
    if (g < NUM_VEC) begin : g_cfg
      assign used_o[g] = (cnt_q[g] != '0);

      // R10: a full counter never wraps to zero
      a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[g] == CNT_MAX) |=> (cnt_q[g] != '0));
    end else begin : g_absent
      assign used_o[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VEC; i++) cnt_q[i] <= '0;
    end else if (cnt_en) begin
      for (int i = 0; i < NUM_VEC; i++) cnt_q[i] <= cnt_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign use_err = err_q;
endmodule

// File: rtl/vm_pend.sv
module vm_pend
  import vm_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_req,
  input  logic [VW-1:0]      irq_vec,
  input  logic [MAX_VEC-1:0] mask_i,
  input  logic [MAX_VEC-1:0] used_i,
  input  logic [MAX_VEC-1:0] clr_i,
  input  logic               msg_ready,
  input  logic [63:0]        lk_addr,
  input  logic [31:0]        lk_data,
  output logic [VW-1:0]      lk_vec,
  output logic [MAX_VEC-1:0] pend_o,
  output logic               msg_valid,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  logic [MAX_VEC-1:0] pend_q, pend_d, ready_set;
  logic               valid_q, valid_d;
  logic [63:0]        addr_q;
  logic [31:0]        data_q;
  logic               slot_free, rep_any, irq_ok, irq_unm, fire;
  logic [VW-1:0]      rep_idx;

  assign slot_free = !valid_q || msg_ready;
  assign ready_set = pend_q & ~mask_i;
  assign rep_any   = |ready_set;
  assign irq_ok    = irq_req && (32'(irq_vec) < NUM_VEC) && used_i[irq_vec];
  assign irq_unm   = !mask_i[irq_vec];
  assign fire      = slot_free && (rep_any || (irq_ok && irq_unm));
  assign lk_vec    = rep_any ? rep_idx : irq_vec;
  assign valid_d   = fire;

  // Lowest pending unmasked vector wins
  always_comb begin
    rep_idx = '0;
    for (int i = MAX_VEC - 1; i >= 0; i--) begin
      if (ready_set[i]) rep_idx = VW'(i);
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (slot_free && rep_any) pend_d[rep_idx] = 1'b0;
    if (irq_ok && (!irq_unm || !slot_free || rep_any)) pend_d[irq_vec] = 1'b1;
    pend_d = pend_d & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (slot_free) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (fire) begin
      addr_q <= lk_addr;
      data_q <= lk_data;
    end
  end

  assign pend_o    = pend_q;
  assign msg_valid = valid_q;
  assign msg_addr  = addr_q;
  assign msg_data  = data_q;

  // R7: a waiting message holds its content until taken
  a_r7_hold_msg: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
  // R5: a rejected request on an idle output yields no message
  a_r5_ignored_no_msg: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ok && !msg_valid && !rep_any) |=> !msg_valid);
  // R6: a masked request on an idle output yields no message
  a_r6_masked_no_msg: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ok && mask_i[irq_vec] && !msg_valid && !rep_any) |=> !msg_valid);
  // R11: a count reaching zero leaves no pending bit behind
  a_r11_clr_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((pend_q & $past(clr_i)) == '0));
endmodule

// File: rtl/vecmsg_ctrl.sv
module vecmsg_ctrl #(
  parameter int NUM_VEC = 8,
  parameter int CNT_W   = 4
) (
  input  logic        clk,
  input  logic        arst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [11:0] bus_addr,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_err,
  input  logic        irq_req,
  input  logic [4:0]  irq_vec,
  input  logic        use_inc,
  input  logic        use_dec,
  input  logic [4:0]  use_vec,
  output logic        use_err,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [63:0] msg_addr,
  output logic [31:0] msg_data
);
  import vm_pkg::*;

  logic [1:0]         rst_sync;
  logic               rst_n;
  logic [MAX_VEC-1:0] mask_w, used_w, clr_w, pend_w;
  logic [VW-1:0]      lk_vec;
  logic [63:0]        lk_addr;
  logic [31:0]        lk_data;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  vm_table #(.NUM_VEC(NUM_VEC)) table_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr[11:2]),
    .bus_size (bus_size),
    .bus_wdata(bus_wdata),
    .pend_i   (pend_w),
    .lk_vec   (lk_vec),
    .mask_o   (mask_w),
    .lk_addr  (lk_addr),
    .lk_data  (lk_data),
    .bus_rdata(bus_rdata),
    .bus_err  (bus_err)
  );

  vm_usecnt #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W)) usecnt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .use_inc(use_inc),
    .use_dec(use_dec),
    .use_vec(use_vec),
    .used_o (used_w),
    .clr_o  (clr_w),
    .use_err(use_err)
  );

  vm_pend #(.NUM_VEC(NUM_VEC)) pend_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .irq_vec  (irq_vec),
    .mask_i   (mask_w),
    .used_i   (used_w),
    .clr_i    (clr_w),
    .msg_ready(msg_ready),
    .lk_addr  (lk_addr),
    .lk_data  (lk_data),
    .lk_vec   (lk_vec),
    .pend_o   (pend_w),
    .msg_valid(msg_valid),
    .msg_addr (msg_addr),
    .msg_data (msg_data)
  );
endmodule

// File: tb/vecmsg_ctrl_tb_top.sv
module vecmsg_ctrl_tb_top;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        bus_req, bus_we;
  logic [11:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_err;
  logic        irq_req;
  logic [4:0]  irq_vec;
  logic        use_inc, use_dec;
  logic [4:0]  use_vec;
  logic        use_err;
  logic        msg_valid, msg_ready;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  vecmsg_ctrl #(.NUM_VEC(NV), .CNT_W(4)) dut_i (
    .clk(clk), .arst_n(arst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .irq_req(irq_req), .irq_vec(irq_vec),
    .use_inc(use_inc), .use_dec(use_dec), .use_vec(use_vec), .use_err(use_err),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic irq_pulse(input logic [4:0] v);
    @(negedge clk);
    irq_req = 1'b1; irq_vec = v;
    @(negedge clk);
    irq_req = 1'b0;
  endtask

  task automatic use_op(input logic inc, input logic dec, input logic [4:0] v);
    @(negedge clk);
    use_inc = inc; use_dec = dec; use_vec = v;
    @(negedge clk);
    use_inc = 1'b0; use_dec = 1'b0;
  endtask

  task automatic take_msg();
    @(negedge clk);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(12'h00C, 2'b10, d); chk("R1 ctrl v0 masked", 64'(d), 64'd1);
    bus_read(12'h07C, 2'b10, d); chk("R1 ctrl v7 masked", 64'(d), 64'd1);
    bus_read(12'h000, 2'b10, d); chk("R1 lo v0 zero", 64'(d), 64'd0);
    bus_read(12'h038, 2'b10, d); chk("R1 data v3 zero", 64'(d), 64'd0);
    bus_read(12'h800, 2'b10, d); chk("R1 pending zero", 64'(d), 64'd0);
    chk("R1 no message", 64'(msg_valid), 64'd0);
  endtask

  task automatic t_rw();
    logic [31:0] d;
    bus_write(12'h000, 32'hA000_0000, 2'b10);
    bus_write(12'h004, 32'h0000_0001, 2'b10);
    bus_write(12'h008, 32'h0000_0100, 2'b10);
    bus_write(12'h010, 32'hB000_0010, 2'b10);
    bus_write(12'h014, 32'h0000_0002, 2'b10);
    bus_write(12'h018, 32'h0000_0201, 2'b10);
    bus_read(12'h004, 2'b10, d); chk("R2 hi v0", 64'(d), 64'h1);
    bus_read(12'h018, 2'b10, d); chk("R2 data v1", 64'(d), 64'h201);
    bus_write(12'h01C, 32'hFFFF_FFFE, 2'b10);
    bus_read(12'h01C, 2'b10, d); chk("R2 ctrl keeps bit0 only", 64'(d), 64'h0);
    bus_write(12'h01C, 32'hFFFF_FFFF, 2'b10);
    bus_read(12'h01C, 2'b10, d); chk("R2 ctrl set", 64'(d), 64'h1);
  endtask

  task automatic t_subword();
    logic [31:0] d;
    bus_write(12'h020, 32'h1234_5678, 2'b00);
    chk("R3 err pulse", 64'(bus_err), 64'd1);
    @(negedge clk);
    chk("R3 err one cycle", 64'(bus_err), 64'd0);
    bus_write(12'h02C, 32'h0, 2'b01);
    bus_read(12'h02C, 2'b10, d); chk("R3 halfword write dropped", 64'(d), 64'h1);
    bus_read(12'h000, 2'b01, d); chk("R3 halfword read zero", 64'(d), 64'h0);
    bus_read(12'h000, 2'b00, d); chk("R3 byte read zero", 64'(d), 64'h0);
  endtask

  task automatic t_region();
    logic [31:0] d;
    bus_write(12'h800, 32'hFFFF_FFFF, 2'b10);
    bus_read(12'h800, 2'b10, d); chk("R4 pending read-only", 64'(d), 64'h0);
    bus_read(12'h804, 2'b10, d); chk("R4 unused pending word", 64'(d), 64'h0);
    bus_write(12'h080, 32'hDEAD_BEEF, 2'b10);
    bus_read(12'h080, 2'b10, d); chk("R4 absent vector reads zero", 64'(d), 64'h0);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    bus_write(12'h00C, 32'h0, 2'b10);
    @(negedge clk);
    irq_pulse(5'd0);
    chk("R5 unused vector no msg", 64'(msg_valid), 64'd0);
    irq_pulse(5'd20);
    chk("R5 out-of-range no msg", 64'(msg_valid), 64'd0);
    bus_read(12'h800, 2'b10, d); chk("R5 no pending", 64'(d), 64'h0);
    bus_write(12'h00C, 32'h1, 2'b10);
  endtask

  task automatic t_mask_replay();
    logic [31:0] d;
    use_op(1'b1, 1'b0, 5'd31);
    chk("R10 inc out-of-range err", 64'(use_err), 64'd1);
    use_op(1'b1, 1'b0, 5'd0);
    chk("R10 inc in range no err", 64'(use_err), 64'd0);
    irq_pulse(5'd0);
    chk("R6 masked no msg", 64'(msg_valid), 64'd0);
    bus_read(12'h800, 2'b10, d); chk("R6 pending set", 64'(d), 64'h1);
    bus_write(12'h00C, 32'h0, 2'b10);
    chk("R8 not yet valid", 64'(msg_valid), 64'd0);
    @(negedge clk);
    chk("R8 replay valid", 64'(msg_valid), 64'd1);
    chk("R8 replay addr", msg_addr, 64'h1_A000_0000);
    chk("R8 replay data", 64'(msg_data), 64'h100);
    bus_read(12'h800, 2'b10, d); chk("R8 pending cleared", 64'(d), 64'h0);
    take_msg();
    chk("R8 consumed", 64'(msg_valid), 64'd0);
  endtask

  task automatic t_direct_busy();
    logic [31:0] d;
    use_op(1'b1, 1'b0, 5'd1);
    bus_write(12'h01C, 32'h0, 2'b10);
    irq_pulse(5'd1);
    chk("R7 valid next cycle", 64'(msg_valid), 64'd1);
    chk("R7 addr", msg_addr, 64'h2_B000_0010);
    chk("R7 data", 64'(msg_data), 64'h201);
    repeat (2) @(negedge clk);
    chk("R7 held", 64'(msg_valid), 64'd1);
    chk("R7 addr held", msg_addr, 64'h2_B000_0010);
    irq_pulse(5'd1);
    irq_pulse(5'd0);
    bus_read(12'h800, 2'b10, d); chk("R9 busy sets pending", 64'(d), 64'h3);
    take_msg();
    chk("R9 replay lowest first", 64'(msg_data), 64'h100);
    bus_read(12'h800, 2'b10, d); chk("R9 one left pending", 64'(d), 64'h2);
    take_msg();
    chk("R9 second replay", 64'(msg_data), 64'h201);
    take_msg();
    chk("R9 drained", 64'(msg_valid), 64'd0);
  endtask

  task automatic t_use_counts();
    logic [31:0] d;
    use_op(1'b1, 1'b0, 5'd2);
    use_op(1'b1, 1'b0, 5'd2);
    irq_pulse(5'd2);
    bus_read(12'h800, 2'b10, d); chk("R6 v2 pending", 64'(d), 64'h4);
    use_op(1'b0, 1'b1, 5'd2);
    bus_read(12'h800, 2'b10, d); chk("R11 nonzero keeps pending", 64'(d), 64'h4);
    use_op(1'b0, 1'b1, 5'd2);
    bus_read(12'h800, 2'b10, d); chk("R11 zero clears pending", 64'(d), 64'h0);
    use_op(1'b0, 1'b1, 5'd2);
    chk("R10 dec at zero no err", 64'(use_err), 64'd0);
    irq_pulse(5'd2);
    bus_read(12'h800, 2'b10, d); chk("R10 dec at zero stays zero", 64'(d), 64'h0);
    use_op(1'b0, 1'b1, 5'd31);
    chk("R10 dec out-of-range no err", 64'(use_err), 64'd0);
    for (int i = 0; i < 16; i++) use_op(1'b1, 1'b0, 5'd3);
    for (int i = 0; i < 14; i++) use_op(1'b0, 1'b1, 5'd3);
    irq_pulse(5'd3);
    bus_read(12'h800, 2'b10, d); chk("R10 count saturates", 64'(d), 64'h8);
    chk("R10 masked v3 no msg", 64'(msg_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    arst_n = 1'b0;
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_size = 2'b10; bus_wdata = '0;
    irq_req = 1'b0; irq_vec = '0;
    use_inc = 1'b0; use_dec = 1'b0; use_vec = '0;
    msg_ready = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rw();
    t_subword();
    t_region();
    t_ignored();
    t_mask_replay();
    t_direct_busy();
    t_use_counts();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule